// File: doc/BRIEF.md
# CAN Status-Change Interrupt Filter

This block sits beside a CAN protocol engine and watches the fault-confinement state of its receive and transmit paths. Each state is one of four levels: OK, warning, error or bus-off. Each direction has its own two-bit sensitivity select, which decides which transitions of that direction count as a status change. A qualifying change sets a sticky status-change flag. Software clears the flag with a strobe. While the flag is pending, the reported receiver and transmitter state fields hold the values they had when the flag was raised.

The block also holds an eight-bit interrupt-enable register. Besides the two sensitivity selects, the register carries one enable for the status-change request and one enable each for three event inputs: wake-up, overrun and receive-full. Each of these enables gates its event into an interrupt request. The block has no streaming data path, so every pin is a plain control or status signal. The two state inputs are sampled on every rising clock edge.

Top module: `can_stat_irq_filter`

## Requirements
- R1: After reset, the enable register reads 0x00, the flag is 0, both reported state fields are 00, and every interrupt output is 0.
- R2: With a direction's sensitivity at 00, no state change of that direction sets the flag.
- R3: With sensitivity 01, a change sets the flag only when the old state or the new state is bus-off (11). All other changes of that direction are ignored.
- R4: With sensitivity 10, a change sets the flag only when the old state or the new state is error (10) or bus-off (11). Moves between OK (00) and warning (01) are ignored.
- R5: With sensitivity 11, every change of state sets the flag. A change is found by comparing the state with its value at the previous clock edge, and the flag is visible one cycle after the edge that sees the change.
- R6: The reported state fields take the current states at each edge where no flag is pending. While the flag is 1 they stay frozen.
- R7: While the transmit state is bus-off, the receiver is treated as bus-off (11). On the first edge after the transmitter moves from bus-off to another state, the receiver is treated as OK (00), whatever its input is.
- R8: The flag stays set until a clear strobe arrives. When a clear strobe and a qualifying change occur in the same cycle, the flag stays 1.
- R9: The status-change request is the flag gated by enable bit 6.
- R10: The enable register is written whole on a write strobe and reads back unchanged. Its layout is: bit 7 wake-up enable, bit 6 status-change enable, bits 5:4 receiver sensitivity, bits 3:2 transmitter sensitivity, bit 1 overrun enable, bit 0 receive-full enable. The wake-up, overrun and receive-full requests are their event inputs ANDed combinationally with bits 7, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_state_i | input | 2 | Receive fault-confinement state |
| tx_state_i | input | 2 | Transmit fault-confinement state |
| cfg_we_i | input | 1 | Write strobe for the enable register |
| cfg_wdata_i | input | 8 | Write data for the enable register |
| cfg_rdata_o | output | 8 | Enable register contents |
| flag_clr_i | input | 1 | Clear strobe for the status-change flag |
| wake_evt_i | input | 1 | Wake-up event |
| ovr_evt_i | input | 1 | Overrun event |
| rxf_evt_i | input | 1 | Receive-full event |
| stat_flag_o | output | 1 | Sticky status-change flag |
| stat_irq_o | output | 1 | Status-change interrupt request |
| wake_irq_o | output | 1 | Wake-up interrupt request |
| ovr_irq_o | output | 1 | Overrun interrupt request |
| rxf_irq_o | output | 1 | Receive-full interrupt request |
| rx_state_o | output | 2 | Reported receiver state |
| tx_state_o | output | 2 | Reported transmitter state |

## Verification
The filter is tried with several state walks:
- An OK-warning-error-bus-off walk at each sensitivity. At 01 it separates bus-off edges from all other edges. At 10 it separates error-level changes from OK/warning changes.
- A walk that changes state while a flag is pending. This separates freezing of the reported fields from tracking of the inputs.
- A clear strobe applied in the same cycle as a qualifying change. This tells a design that keeps the event from one that drops it.
- A transmitter walk from bus-off back to OK while the receiver input is non-zero. This shows whether the receiver is forced to OK.

A behavioural model is also compared with the design on every cycle.

// File: rtl/can_sif_pkg.sv
package can_sif_pkg;
  localparam int STW  = 2;
  localparam int NDIR = 2;
  localparam int CFGW = 8;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  typedef logic [STW-1:0] fc_state_t;
  localparam fc_state_t ST_OK   = 2'b00;
  localparam fc_state_t ST_WARN = 2'b01;
  localparam fc_state_t ST_ERR  = 2'b10;
  localparam fc_state_t ST_BOFF = 2'b11;

  localparam int B_WAKE  = 7;
  localparam int B_STAT  = 6;
  localparam int B_RXS_H = 5;
  localparam int B_RXS_L = 4;
  localparam int B_TXS_H = 3;
  localparam int B_TXS_L = 2;
  localparam int B_OVR   = 1;
  localparam int B_RXF   = 0;
endpackage

// File: rtl/can_sif_cfg_reg.sv
module can_sif_cfg_reg
  import can_sif_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [CFGW-1:0] wdata_i,
  output logic [CFGW-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/can_sif_dir_filter.sv
module can_sif_dir_filter
  import can_sif_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  fc_state_t cur_i,
  input  logic [1:0] sens_i,
  output fc_state_t prev_o,
  output logic      hit_o
);
  logic moved, touches_boff, touches_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= ST_OK;
    else        prev_o <= cur_i;
  end

  // error and bus-off both have the upper state bit set
  always_comb begin
    moved        = (cur_i != prev_o);
    touches_boff = (cur_i == ST_BOFF) || (prev_o == ST_BOFF);
    touches_err  = cur_i[STW-1] || prev_o[STW-1];
    unique case (sens_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = moved && touches_boff;
      2'b10:   hit_o = moved && touches_err;
      default: hit_o = moved;
    endcase
  end
endmodule

// File: rtl/can_sif_flag.sv
module can_sif_flag
  import can_sif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NDIR-1:0]      hit_i,
  input  logic                 clr_i,
  input  fc_state_t            rx_cur_i,
  input  fc_state_t            tx_cur_i,
  output logic                 flag_o,
  output fc_state_t            rx_rpt_o,
  output fc_state_t            tx_rpt_o
);
  logic flag_d;
  assign flag_d = (|hit_i) || (flag_o && !clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o   <= 1'b0;
      rx_rpt_o <= ST_OK;
      tx_rpt_o <= ST_OK;
    end else begin
      flag_o <= flag_d;
      if (!flag_o) begin
        rx_rpt_o <= rx_cur_i;
        tx_rpt_o <= tx_cur_i;
      end
    end
  end
endmodule

// File: rtl/can_stat_irq_filter.sv
module can_stat_irq_filter
  import can_sif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_state_i,
  input  logic [1:0] tx_state_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_rdata_o,
  input  logic       flag_clr_i,
  input  logic       wake_evt_i,
  input  logic       ovr_evt_i,
  input  logic       rxf_evt_i,
  output logic       stat_flag_o,
  output logic       stat_irq_o,
  output logic       wake_irq_o,
  output logic       ovr_irq_o,
  output logic       rxf_irq_o,
  output logic [1:0] rx_state_o,
  output logic [1:0] tx_state_o
);
  logic [CFGW-1:0]           cfg_q;
  logic [NDIR-1:0][STW-1:0]  cur, prev;
  logic [NDIR-1:0][1:0]      sens;
  logic [NDIR-1:0]           hit;

  can_sif_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .q_o(cfg_q)
  );

  assign sens[DIR_RX] = cfg_q[B_RXS_H:B_RXS_L];
  assign sens[DIR_TX] = cfg_q[B_TXS_H:B_TXS_L];

  // receiver is coded bus-off while the transmitter is; recovery forces OK
  assign cur[DIR_TX] = tx_state_i;
  assign cur[DIR_RX] = (tx_state_i == ST_BOFF) ? ST_BOFF :
                       (prev[DIR_TX] == ST_BOFF) ? ST_OK : rx_state_i;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    can_sif_dir_filter u_filt (
      .clk(clk), .rst_n(rst_n), .cur_i(cur[d]), .sens_i(sens[d]),
      .prev_o(prev[d]), .hit_o(hit[d])
    );
  end

  can_sif_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(flag_clr_i),
    .rx_cur_i(cur[DIR_RX]), .tx_cur_i(cur[DIR_TX]),
    .flag_o(stat_flag_o), .rx_rpt_o(rx_state_o), .tx_rpt_o(tx_state_o)
  );

  assign cfg_rdata_o = cfg_q;
  assign stat_irq_o  = stat_flag_o & cfg_q[B_STAT];
  assign wake_irq_o  = wake_evt_i  & cfg_q[B_WAKE];
  assign ovr_irq_o   = ovr_evt_i   & cfg_q[B_OVR];
  assign rxf_irq_o   = rxf_evt_i   & cfg_q[B_RXF];
endmodule

// File: rtl/can_sif_chk.sv
module can_sif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rx_state_i,
  input logic [1:0] tx_state_i,
  input logic       cfg_we_i,
  input logic [7:0] cfg_wdata_i,
  input logic [7:0] cfg_rdata_o,
  input logic       flag_clr_i,
  input logic       wake_evt_i,
  input logic       ovr_evt_i,
  input logic       rxf_evt_i,
  input logic       stat_flag_o,
  input logic       stat_irq_o,
  input logic       wake_irq_o,
  input logic       ovr_irq_o,
  input logic       rxf_irq_o,
  input logic [1:0] rx_state_o,
  input logic [1:0] tx_state_o
);
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_flag_o && !cfg_we_i && cfg_rdata_o[5:2] == 4'b0000) |=> !stat_flag_o);

  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    stat_flag_o |=> ($stable(rx_state_o) && $stable(tx_state_o)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flag_o && !flag_clr_i) |=> stat_flag_o);

  a_r7_tx_boff_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_flag_o && tx_state_i == 2'b11) |=> (rx_state_o == 2'b11 && tx_state_o == 2'b11));

  a_r10_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> (cfg_rdata_o == $past(cfg_wdata_i)));

  always_comb begin
    if (rst_n) a_r9_irq_gate: assert (!stat_irq_o || cfg_rdata_o[6]);
  end
endmodule

bind can_stat_irq_filter can_sif_chk u_chk (.*);

// File: tb/tb_can_stat_irq_filter.sv
module tb_can_stat_irq_filter;
  logic clk = 0, rst_n = 0;
  logic [1:0] rx_state_i = 0, tx_state_i = 0;
  logic cfg_we_i = 0;
  logic [7:0] cfg_wdata_i = 0;
  logic flag_clr_i = 0, wake_evt_i = 0, ovr_evt_i = 0, rxf_evt_i = 0;
  logic [7:0] cfg_rdata_o;
  logic stat_flag_o, stat_irq_o, wake_irq_o, ovr_irq_o, rxf_irq_o;
  logic [1:0] rx_state_o, tx_state_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference
  int m_cfg = 0, m_flag = 0, m_rxr = 0, m_txr = 0, m_rxp = 0, m_txp = 0;

  always #5 clk = ~clk;

  can_stat_irq_filter dut (.*);

  function automatic bit qual(int s, int a, int b);
    if (a == b) return 0;
    if (s == 3) return 1;
    if (s == 2) return (a >= 2) || (b >= 2);
    if (s == 1) return (a == 3) || (b == 3);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_flag = 0; m_rxr = 0; m_txr = 0; m_rxp = 0; m_txp = 0;
    end else begin
      int erx, etx, hit;
      etx = tx_state_i;
      if (etx == 3) erx = 3;
      else if (m_txp == 3) erx = 0;
      else erx = rx_state_i;
      hit = qual((m_cfg >> 4) & 3, m_rxp, erx) || qual((m_cfg >> 2) & 3, m_txp, etx);
      if (m_flag == 0) begin m_rxr = erx; m_txr = etx; end
      m_flag = (hit || (m_flag && !flag_clr_i)) ? 1 : 0;
      m_rxp = erx; m_txp = etx;
      if (cfg_we_i) m_cfg = cfg_wdata_i;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("MODEL-R8 flag", stat_flag_o, m_flag);
    chk("MODEL-R9 irq", stat_irq_o, m_flag & ((m_cfg >> 6) & 1));
    chk("MODEL-R6 rx", rx_state_o, m_rxr);
    chk("MODEL-R6 tx", tx_state_o, m_txr);
    chk("MODEL-R10 cfg", cfg_rdata_o, m_cfg);
    chk("MODEL-R10 wake", wake_irq_o, wake_evt_i & ((m_cfg >> 7) & 1));
    chk("MODEL-R10 ovr", ovr_irq_o, ovr_evt_i & ((m_cfg >> 1) & 1));
    chk("MODEL-R10 rxf", rxf_irq_o, rxf_evt_i & (m_cfg & 1));
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) cmp_model();
  endtask

  task automatic wr(logic [7:0] v);
    cfg_we_i = 1; cfg_wdata_i = v; step(); cfg_we_i = 0;
  endtask

  task automatic clr();
    flag_clr_i = 1; step(); flag_clr_i = 0; step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cfg", cfg_rdata_o, 0);
    chk("R1 flag", stat_flag_o, 0);
    chk("R1 rx", rx_state_o, 0);
    chk("R1 tx", tx_state_o, 0);
    chk("R1 irq", stat_irq_o | wake_irq_o | ovr_irq_o | rxf_irq_o, 0);
    rst_n = 1;
    step();

    // R2: sensitivity 00 everywhere
    for (int s = 1; s <= 4; s++) begin
      rx_state_i = s[1:0]; step();
      chk("R2 no flag", stat_flag_o, 0);
    end
    step();

    // R3: receiver sensitivity 01
    wr(8'h10);
    rx_state_i = 1; step(); chk("R3 ok->warn ignored", stat_flag_o, 0);
    rx_state_i = 2; step(); chk("R3 warn->err ignored", stat_flag_o, 0);
    rx_state_i = 3; step(); chk("R3 enter bus-off", stat_flag_o, 1);
    clr(); chk("R8 cleared", stat_flag_o, 0);
    rx_state_i = 0; step(); chk("R3 leave bus-off", stat_flag_o, 1);
    clr();

    // R4: transmitter sensitivity 10
    wr(8'h08);
    tx_state_i = 1; step(); chk("R4 ok->warn ignored", stat_flag_o, 0);
    tx_state_i = 0; step(); chk("R4 warn->ok ignored", stat_flag_o, 0);
    tx_state_i = 2; step(); chk("R4 enter error", stat_flag_o, 1);
    clr();
    tx_state_i = 1; step(); chk("R4 leave error", stat_flag_o, 1);
    clr();
    tx_state_i = 0; step(); step();

    // R5/R9/R6: receiver sensitivity 11 with status enable
    wr(8'h70);
    rx_state_i = 1; step();
    chk("R5 any change", stat_flag_o, 1);
    chk("R9 irq", stat_irq_o, 1);
    chk("R6 captured", rx_state_o, 1);
    rx_state_i = 2; step();
    chk("R6 frozen", rx_state_o, 1);
    flag_clr_i = 1; step(); flag_clr_i = 0;
    chk("R8 clear", stat_flag_o, 0);
    chk("R6 still frozen", rx_state_o, 1);
    step();
    chk("R6 tracks after clear", rx_state_o, 2);

    // R8: clear and qualifying change in the same cycle
    flag_clr_i = 1; rx_state_i = 1; step(); flag_clr_i = 0;
    chk("R8 event kept", stat_flag_o, 1);
    clr();

    // R9: enable off hides the request
    wr(8'h30);
    rx_state_i = 0; step();
    chk("R9 flag", stat_flag_o, 1);
    chk("R9 gated", stat_irq_o, 0);
    clr();

    // R7: transmitter bus-off and recovery
    wr(8'h00);
    rx_state_i = 1; tx_state_i = 3; step(); step();
    chk("R7 tx boff", tx_state_o, 3);
    chk("R7 rx boff", rx_state_o, 3);
    tx_state_i = 0; step();
    chk("R7 rx forced ok", rx_state_o, 0);
    step();
    chk("R7 rx follows", rx_state_o, 1);
    rx_state_i = 0; step();

    // R10: enables and readback
    wr(8'h83);
    chk("R10 readback", cfg_rdata_o, 8'h83);
    wake_evt_i = 1; ovr_evt_i = 1; rxf_evt_i = 1; #1;
    chk("R10 wake", wake_irq_o, 1);
    chk("R10 ovr", ovr_irq_o, 1);
    chk("R10 rxf", rxf_irq_o, 1);
    step();
    wr(8'h00); #1;
    chk("R10 wake off", wake_irq_o, 0);
    chk("R10 ovr off", ovr_irq_o, 0);
    chk("R10 rxf off", rxf_irq_o, 0);
    wake_evt_i = 0; ovr_evt_i = 0; rxf_evt_i = 0;

    // mixed walk, checked by the model each cycle
    wr(8'h5E);
    for (int i = 0; i < 200; i++) begin
      rx_state_i = 2'((i * 7 + i / 3) % 4);
      tx_state_i = 2'((i * 5 + 1) % 4);
      flag_clr_i = (i % 3 == 0);
      step();
    end
    flag_clr_i = 0;
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule